// File: doc/BRIEF.md
# Indexed-Colour Display Register Interface

This block is the host-facing register file of an indexed-colour display controller. A host reaches it with 32-bit word reads and writes at byte addresses. The block decodes each address into one of several regions: three table regions (main colour lookup, a three-entry cursor colour set and a cursor bitmap), a handful of scalar registers (display width, display height, a control word, the frame start offset and the pointer location) and a soft-reset trigger. A group of legacy timing addresses is accepted and has no effect.

Table writes leave the block as a one-cycle strobe that carries a slot number and data, so that RAMs outside the block capture them. The three cursor colours are also held here so that the host can read them back. The scalar state goes straight to the pixel pipeline in pixel units, together with a decoded bits-per-pixel value. A frame-complete pulse from the scan-out side raises an interrupt, and any host write drops it.

Top module: `dispctl_regs`

## Requirements
- R1: A write to 0x800..0xFFF produces `pal_we` high for exactly one cycle, in the cycle after the write. It comes with `arr_idx` = (addr−0x800)>>3 and `arr_data` = wdata[23:0], with red in [23:16], green in [15:8] and blue in [7:0].
- R2: A write to 0x508..0x51F produces `cpal_we` for one cycle, with `arr_idx` = (addr−0x508)>>3 (0..2) and `arr_data` = wdata[23:0]. The entry is stored, and a read anywhere in that range returns {8'h00, stored entry}.
- R3: A write to 0x1000..0x1FFF produces `pat_we` for one cycle, with `arr_idx` = (addr−0x1000)>>3 (0..511) and `arr_data` = {8'h00, wdata[15:0]}.
- R4: A write of v to 0x118 sets `width_px` = 4·v, truncated to DIM_W bits. A read of 0x118 returns `width_px`/4.
- R5: A write of v to 0x150 sets `height_px` = floor(v/2). A read of 0x150 returns 2·`height_px`, so an odd value reads back one lower.
- R6: The control word at 0x300 reads back as written. Bit 10 drives `force_blank` and bit 23 drives `cursor_off`. Bits [22:20] = 0..7 give `depth_bpp` = 1, 2, 4, 8, 15, 16, 0, 0.
- R7: A write to 0x400 sets `top_ofs`, and a write to 0x638 sets `cursor_pos`, both to the full 32-bit value.
- R8: Writes to 0x000, 0x108, 0x110, 0x120, 0x128, 0x130, 0x138, 0x140, 0x148, 0x158, 0x160, 0x168, 0x170 and 0x200 change no output and raise no strobe. Reads of any address outside 0x118, 0x150, 0x300 and 0x508..0x51F return 0, and so does any read with `rd_en` low.
- R9: A `frame_done` pulse sets `irq` in the next cycle. Any write clears `irq` in the next cycle, and a write wins over a `frame_done` in the same cycle.
- R10: A write to 0x100000 clears, in the next cycle, the control word, width, height, `top_ofs`, `cursor_pos`, the stored cursor colours and `irq`. It also pulses `ram_clr` for one cycle so that the external tables are wiped.
- R11: After reset every output is zero, except `depth_bpp`, which is 1 (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write request for this cycle |
| rd_en | input | 1 | Host read request for this cycle |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| frame_done | input | 1 | One-cycle pulse at the end of a frame refresh |
| irq | output | 1 | Frame interrupt |
| pal_we | output | 1 | Colour lookup write strobe |
| cpal_we | output | 1 | Cursor colour write strobe |
| pat_we | output | 1 | Cursor bitmap write strobe |
| ram_clr | output | 1 | Wipe strobe for the external tables |
| arr_idx | output | 9 | Slot number for the active strobe |
| arr_data | output | 24 | Data for the active strobe |
| width_px | output | DIM_W | Display width in pixels |
| height_px | output | DIM_W | Display height in lines |
| depth_bpp | output | 5 | Decoded bits per pixel |
| top_ofs | output | 32 | Frame start offset |
| cursor_pos | output | 32 | Pointer location word |
| force_blank | output | 1 | Blank the display |
| cursor_off | output | 1 | Hide the pointer |

## Verification
The bench aims at the edges of each table region. It writes the last byte of a range so that a decoder with an off-by-one bound either drops the strobe or sends it to a neighbour. It writes an odd height, because a design that stored the raw value would read it back unchanged. It sweeps all eight depth codes, so that a swapped table entry shows at once. It sends a write and a frame pulse in the same cycle, and a design with the wrong priority would leave the interrupt raised. It also writes every legacy timing address with all ones, and a decoder that let one of them fall into a scalar or table region would then move an output or fire a strobe that the scoreboard does not expect.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_PAL, RG_CURPAL, RG_PAT, RG_WIDTH, RG_HEIGHT,
    RG_CTRL, RG_TOP, RG_CPOS, RG_SRST, RG_TIMING
  } region_e;

  localparam logic [31:0] PAL_LO   = 32'h0000_0800;
  localparam logic [31:0] PAL_HI   = 32'h0000_1000;
  localparam logic [31:0] CPAL_LO  = 32'h0000_0508;
  localparam logic [31:0] CPAL_HI  = 32'h0000_0520;
  localparam logic [31:0] PAT_LO   = 32'h0000_1000;
  localparam logic [31:0] PAT_HI   = 32'h0000_2000;
  localparam logic [31:0] A_WIDTH  = 32'h0000_0118;
  localparam logic [31:0] A_HEIGHT = 32'h0000_0150;
  localparam logic [31:0] A_CTRL   = 32'h0000_0300;
  localparam logic [31:0] A_TOP    = 32'h0000_0400;
  localparam logic [31:0] A_CPOS   = 32'h0000_0638;
  localparam logic [31:0] A_SRST   = 32'h0010_0000;

  localparam int BLANK_BIT = 10;
  localparam int NOCUR_BIT = 23;
  localparam int DEPTH_LSB = 20;

  function automatic logic [4:0] depth_of(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      3'd4:    return 5'd15;
      3'd5:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic is_timing(input logic [31:0] a);
    case (a)
      32'h000, 32'h108, 32'h110, 32'h120, 32'h128, 32'h130, 32'h138,
      32'h140, 32'h148, 32'h158, 32'h160, 32'h168, 32'h170, 32'h200:
        return 1'b1;
      default:
        return 1'b0;
    endcase
  endfunction

  function automatic logic [8:0] slot_of(input logic [31:0] a, input logic [31:0] base);
    return 9'((a - base) >> 3);
  endfunction

endpackage

// File: rtl/dispctl_decode.sv
module dispctl_decode
  import dispctl_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [8:0]        index
);
  logic [31:0] a32;
  assign a32 = 32'(addr);

  always_comb begin
    region = RG_NONE;
    index  = '0;
    if (a32 >= PAL_LO && a32 < PAL_HI) begin
      region = RG_PAL;
      index  = slot_of(a32, PAL_LO);
    end else if (a32 >= PAT_LO && a32 < PAT_HI) begin
      region = RG_PAT;
      index  = slot_of(a32, PAT_LO);
    end else if (a32 >= CPAL_LO && a32 < CPAL_HI) begin
      region = RG_CURPAL;
      index  = slot_of(a32, CPAL_LO);
    end else if (a32 == A_WIDTH)  region = RG_WIDTH;
    else if (a32 == A_HEIGHT)     region = RG_HEIGHT;
    else if (a32 == A_CTRL)       region = RG_CTRL;
    else if (a32 == A_TOP)        region = RG_TOP;
    else if (a32 == A_CPOS)       region = RG_CPOS;
    else if (a32 == A_SRST)       region = RG_SRST;
    else if (is_timing(a32))      region = RG_TIMING;
  end
endmodule

// File: rtl/dispctl_curpal.sv
module dispctl_curpal #(
  parameter int N_ENT = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [23:0]      wrgb,
  input  logic [IDX_W-1:0] ridx,
  output logic [23:0]      rrgb
);
  logic [23:0] ent [N_ENT];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           ent[e] <= '0;
      else if (clr)                         ent[e] <= '0;
      else if (we && widx == IDX_W'(e))     ent[e] <= wrgb;
    end
  end

  always_comb begin
    rrgb = '0;
    for (int e = 0; e < N_ENT; e++)
      if (ridx == IDX_W'(e)) rrgb = ent[e];
  end
endmodule

// File: rtl/dispctl_irq.sv
module dispctl_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (clr_evt) irq <= 1'b0;
    else if (set_evt) irq <= 1'b1;
  end
endmodule

// File: rtl/dispctl_regs.sv
module dispctl_regs
  import dispctl_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DIM_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              frame_done,
  output logic              irq,
  output logic              pal_we,
  output logic              cpal_we,
  output logic              pat_we,
  output logic              ram_clr,
  output logic [8:0]        arr_idx,
  output logic [23:0]       arr_data,
  output logic [DIM_W-1:0]  width_px,
  output logic [DIM_W-1:0]  height_px,
  output logic [4:0]        depth_bpp,
  output logic [31:0]       top_ofs,
  output logic [31:0]       cursor_pos,
  output logic              force_blank,
  output logic              cursor_off
);
  localparam int CP_ENT = 3;
  localparam int CP_IW  = $clog2(CP_ENT);

  function automatic logic [DIM_W-1:0] px_from_quads(input logic [DIM_W-3:0] v);
    return {v, 2'b00};
  endfunction

  function automatic logic [31:0] quads_from_px(input logic [DIM_W-1:0] w);
    return 32'(w >> 2);
  endfunction

  function automatic logic [31:0] halflines_from_lines(input logic [DIM_W-1:0] h);
    return 32'({h, 1'b0});
  endfunction

  region_e     rg;
  logic [8:0]  slot;
  logic [23:0] cp_rgb;
  logic [31:0] ctrl_q;

  // named events for the checker
  logic wr_pal_hit, wr_pat_hit, wr_cpal_hit, srst_hit, timing_hit;
  assign wr_pal_hit  = wr_en && rg == RG_PAL;
  assign wr_pat_hit  = wr_en && rg == RG_PAT;
  assign wr_cpal_hit = wr_en && rg == RG_CURPAL;
  assign srst_hit    = wr_en && rg == RG_SRST;
  assign timing_hit  = wr_en && rg == RG_TIMING;

  dispctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (addr),
    .region (rg),
    .index  (slot)
  );

  dispctl_curpal #(.N_ENT(CP_ENT), .IDX_W(CP_IW)) u_cpal (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (srst_hit),
    .we    (wr_cpal_hit),
    .widx  (slot[CP_IW-1:0]),
    .wrgb  (wdata[23:0]),
    .ridx  (slot[CP_IW-1:0]),
    .rrgb  (cp_rgb)
  );

  dispctl_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (frame_done),
    .clr_evt (wr_en),
    .irq     (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pal_we     <= 1'b0;
      cpal_we    <= 1'b0;
      pat_we     <= 1'b0;
      ram_clr    <= 1'b0;
      arr_idx    <= '0;
      arr_data   <= '0;
      width_px   <= '0;
      height_px  <= '0;
      ctrl_q     <= '0;
      top_ofs    <= '0;
      cursor_pos <= '0;
    end else begin
      pal_we  <= 1'b0;
      cpal_we <= 1'b0;
      pat_we  <= 1'b0;
      ram_clr <= 1'b0;
      if (wr_en) begin
        case (rg)
          RG_PAL: begin
            pal_we   <= 1'b1;
            arr_idx  <= slot;
            arr_data <= wdata[23:0];
          end
          RG_CURPAL: begin
            cpal_we  <= 1'b1;
            arr_idx  <= slot;
            arr_data <= wdata[23:0];
          end
          RG_PAT: begin
            pat_we   <= 1'b1;
            arr_idx  <= slot;
            arr_data <= {8'h00, wdata[15:0]};
          end
          RG_WIDTH:  width_px   <= px_from_quads(wdata[DIM_W-3:0]);
          RG_HEIGHT: height_px  <= wdata[DIM_W:1];
          RG_CTRL:   ctrl_q     <= wdata;
          RG_TOP:    top_ofs    <= wdata;
          RG_CPOS:   cursor_pos <= wdata;
          RG_SRST: begin
            ram_clr    <= 1'b1;
            width_px   <= '0;
            height_px  <= '0;
            ctrl_q     <= '0;
            top_ofs    <= '0;
            cursor_pos <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  assign force_blank = ctrl_q[BLANK_BIT];
  assign cursor_off  = ctrl_q[NOCUR_BIT];
  assign depth_bpp   = depth_of(ctrl_q[DEPTH_LSB+2:DEPTH_LSB]);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (rg)
        RG_WIDTH:  rdata = quads_from_px(width_px);
        RG_HEIGHT: rdata = halflines_from_lines(height_px);
        RG_CTRL:   rdata = ctrl_q;
        RG_CURPAL: rdata = {8'h00, cp_rgb};
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dispctl_regs_chk.sv
module dispctl_regs_chk #(
  parameter int ADDR_W = 21,
  parameter int DIM_W  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              frame_done,
  input logic              irq,
  input logic              pal_we,
  input logic              cpal_we,
  input logic              pat_we,
  input logic              ram_clr,
  input logic [8:0]        arr_idx,
  input logic [DIM_W-1:0]  width_px,
  input logic [DIM_W-1:0]  height_px,
  input logic [31:0]       top_ofs,
  input logic [31:0]       cursor_pos,
  input logic              wr_pal_hit,
  input logic              wr_pat_hit,
  input logic              srst_hit,
  input logic              timing_hit
);
  AST_PAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pal_hit |=> pal_we && arr_idx == {1'b0, $past(addr[10:3])}); // R1
  AST_PAT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pat_hit |=> pat_we && arr_idx == $past(addr[11:3])); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pal_we, cpal_we, pat_we, ram_clr})); // R2
  AST_IRQ_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !irq); // R9
  AST_IRQ_FRAME_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !wr_en |=> irq); // R9
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_hit |=> ram_clr && width_px == '0 && height_px == '0 && top_ofs == '0 && cursor_pos == '0); // R10
  AST_TIMING_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    timing_hit |=> $stable(width_px) && $stable(height_px) && $stable(top_ofs)
                   && $stable(cursor_pos) && !pal_we && !pat_we && !cpal_we); // R8
endmodule

bind dispctl_regs dispctl_regs_chk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .frame_done (frame_done),
  .irq        (irq),
  .pal_we     (pal_we),
  .cpal_we    (cpal_we),
  .pat_we     (pat_we),
  .ram_clr    (ram_clr),
  .arr_idx    (arr_idx),
  .width_px   (width_px),
  .height_px  (height_px),
  .top_ofs    (top_ofs),
  .cursor_pos (cursor_pos),
  .wr_pal_hit (wr_pal_hit),
  .wr_pat_hit (wr_pat_hit),
  .srst_hit   (srst_hit),
  .timing_hit (timing_hit)
);

// File: tb/tb_dispctl_regs.sv
module tb_dispctl_regs;
  localparam int AW = 21;
  localparam int DW = 14;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, frame_done = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, pal_we, cpal_we, pat_we, ram_clr, force_blank, cursor_off;
  logic [8:0] arr_idx;
  logic [23:0] arr_data;
  logic [DW-1:0] width_px, height_px;
  logic [4:0] depth_bpp;
  logic [31:0] top_ofs, cursor_pos;

  always #10 clk = ~clk;

  dispctl_regs #(.ADDR_W(AW), .DIM_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .frame_done(frame_done), .irq(irq),
    .pal_we(pal_we), .cpal_we(cpal_we), .pat_we(pat_we), .ram_clr(ram_clr),
    .arr_idx(arr_idx), .arr_data(arr_data), .width_px(width_px),
    .height_px(height_px), .depth_bpp(depth_bpp), .top_ofs(top_ofs),
    .cursor_pos(cursor_pos), .force_blank(force_blank), .cursor_off(cursor_off)
  );

  typedef struct packed {
    logic [1:0]  kind;   // 0 colour, 1 cursor colour, 2 bitmap, 3 wipe
    logic [8:0]  idx;
    logic [23:0] data;
  } item_t;

  item_t expq[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [8:0] i, input logic [23:0] d);
    item_t it;
    it.kind = k; it.idx = i; it.data = d;
    expq.push_back(it);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); rd_en = 1'b1;
    #2 d = rdata;
    rd_en = 1'b0;
  endtask

  // monitor: pops expected strobes from the scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && (pal_we || cpal_we || pat_we || ram_clr)) begin
      item_t got;
      string req;
      got.kind = ram_clr ? 2'd3 : pat_we ? 2'd2 : cpal_we ? 2'd1 : 2'd0;
      got.idx  = ram_clr ? 9'd0 : arr_idx;
      got.data = ram_clr ? 24'd0 : arr_data;
      req = (got.kind == 2'd0) ? "R1" : (got.kind == 2'd1) ? "R2" :
            (got.kind == 2'd2) ? "R3" : "R10";
      if (expq.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL %s unexpected strobe got=%h exp=none", req, got);
      end else begin
        item_t e;
        e = expq.pop_front();
        check(req, 32'(got), 32'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int dtab[8] = '{1, 2, 4, 8, 15, 16, 0, 0};
    logic [31:0] tims[14] = '{32'h000, 32'h108, 32'h110, 32'h120, 32'h128, 32'h130, 32'h138,
                              32'h140, 32'h148, 32'h158, 32'h160, 32'h168, 32'h170, 32'h200};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    check("R11 irq", 32'(irq), 0);
    check("R11 width", 32'(width_px), 0);
    check("R11 height", 32'(height_px), 0);
    check("R11 depth", 32'(depth_bpp), 1);
    check("R11 blank/cursor", {30'd0, force_blank, cursor_off}, 0);
    check("R11 top", top_ofs, 0);
    rd(32'h300, r); check("R11 ctrl read", r, 0);

    // R1 colour lookup strobes, first, last slot and last byte
    push(0, 9'd0, 24'h112233);   wr(32'h800, 32'hAA112233);
    push(0, 9'd255, 24'h445566); wr(32'hFF8, 32'h00445566);
    push(0, 9'd255, 24'h778899); wr(32'hFFF, 32'hFF778899);
    push(0, 9'd17, 24'hFFFFFF);  wr(32'h88C, 32'hFFFFFFFF);

    // R2 cursor colours stored and read back
    push(1, 9'd0, 24'hA0B0C0); wr(32'h508, 32'hFFA0B0C0);
    push(1, 9'd1, 24'h010203); wr(32'h510, 32'h00010203);
    push(1, 9'd2, 24'h0D0E0F); wr(32'h518, 32'h000D0E0F);
    push(1, 9'd2, 24'h5A5A5A); wr(32'h51F, 32'h005A5A5A);
    rd(32'h508, r); check("R2 entry0", r, 32'h00A0B0C0);
    rd(32'h514, r); check("R2 entry1", r, 32'h00010203);
    rd(32'h51C, r); check("R2 entry2", r, 32'h005A5A5A);

    // R3 cursor bitmap strobes
    push(2, 9'd0, 24'h001234);   wr(32'h1000, 32'hDEAD1234);
    push(2, 9'd511, 24'h00BEEF); wr(32'h1FF8, 32'h0000BEEF);
    push(2, 9'd256, 24'h00FFFF); wr(32'h1800, 32'hFFFFFFFF);

    // R4 width
    wr(32'h118, 32'd320);
    check("R4 width px", 32'(width_px), 1280);
    rd(32'h118, r); check("R4 width read", r, 320);
    wr(32'h118, 32'hFFFFFFFF);
    check("R4 width trunc", 32'(width_px), 32'h3FFC);
    rd(32'h118, r); check("R4 width trunc read", r, 32'hFFF);
    wr(32'h118, 32'd256);

    // R5 height
    wr(32'h150, 32'd961);
    check("R5 height odd", 32'(height_px), 480);
    rd(32'h150, r); check("R5 height read", r, 960);
    wr(32'h150, 32'd1200);
    check("R5 height even", 32'(height_px), 600);

    // R6 control word and depth table
    wr(32'h300, 32'h0080_0400);
    check("R6 blank", 32'(force_blank), 1);
    check("R6 cursor off", 32'(cursor_off), 1);
    rd(32'h300, r); check("R6 ctrl read", r, 32'h0080_0400);
    for (int c = 0; c < 8; c++) begin
      wr(32'h300, 32'(c) << 20);
      check($sformatf("R6 depth code %0d", c), 32'(depth_bpp), 32'(dtab[c]));
      check("R6 flags clear", {30'd0, force_blank, cursor_off}, 0);
    end
    wr(32'h300, 32'h0035_0000);
    rd(32'h300, r); check("R6 ctrl read2", r, 32'h0035_0000);

    // R7 offset and pointer
    wr(32'h400, 32'h1234_5678);
    check("R7 top", top_ofs, 32'h1234_5678);
    wr(32'h638, 32'h0040_0020);
    check("R7 cursor pos", cursor_pos, 32'h0040_0020);

    // R8 timing writes ignored, unmapped reads are zero
    foreach (tims[i]) wr(tims[i], 32'hFFFFFFFF);
    check("R8 width kept", 32'(width_px), 1024);
    check("R8 height kept", 32'(height_px), 600);
    check("R8 top kept", top_ofs, 32'h1234_5678);
    check("R8 cpos kept", cursor_pos, 32'h0040_0020);
    rd(32'h300, r); check("R8 ctrl kept", r, 32'h0035_0000);
    rd(32'h800, r);  check("R8 read colour", r, 0);
    rd(32'h1000, r); check("R8 read bitmap", r, 0);
    rd(32'h638, r);  check("R8 read pointer", r, 0);
    rd(32'h777, r);  check("R8 read hole", r, 0);
    @(negedge clk); addr = AW'(32'h300); #2 check("R8 rd_en low", rdata, 0);

    // R9 interrupt
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    check("R9 set", 32'(irq), 1);
    repeat (3) @(negedge clk);
    check("R9 held", 32'(irq), 1);
    wr(32'h108, 32'h0);
    check("R9 write clears", 32'(irq), 0);
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    @(negedge clk);
    addr = '0; wdata = '0; wr_en = 1'b1; frame_done = 1'b1;
    @(negedge clk); wr_en = 1'b0; frame_done = 1'b0;
    check("R9 write wins", 32'(irq), 0);

    // R10 soft reset
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    push(3, 9'd0, 24'd0);
    wr(32'h100000, 32'h0);
    check("R10 irq", 32'(irq), 0);
    check("R10 width", 32'(width_px), 0);
    check("R10 height", 32'(height_px), 0);
    check("R10 top", top_ofs, 0);
    check("R10 cpos", cursor_pos, 0);
    check("R10 depth", 32'(depth_bpp), 1);
    rd(32'h300, r); check("R10 ctrl", r, 0);
    rd(32'h508, r); check("R10 cursor colour", r, 0);

    repeat (3) @(negedge clk);
    check("R1 scoreboard drained", 32'(expq.size()), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule